// File: doc/BRIEF.md
# Benes Permutation Network with Hardwired Switches

This block reorders a vector of `P` data words into any order, through a rearrangeable multistage network of 2x2 exchange elements. The network has `2*log2(P)-1` columns of `P/2` elements. Each element either passes its two words straight through or swaps them, as one configuration bit selects. A routing step outside the block computes the configuration vector for a wanted permutation. The vector is presented on a port together with the data, and it may change every cycle.

Schedules often leave some elements in the same state on every cycle. A parameter mask marks those elements, and a second parameter gives each one its fixed state. At elaboration a marked element becomes plain pass or cross wiring, with no multiplexer, and its configuration bit is ignored. A further parameter places a register after every column. The configuration then travels through matching delay lines, so each data vector meets the settings that were presented with it.

Top module: `benes_perm_net`

## Requirements
- R1: A configuration bit of 0 puts its element in pass (upper output takes upper input). A bit of 1 puts it in cross (upper output takes lower input). With every bit 0, `dout` equals `din`.
- R2: Word i sits at bits [i*W +: W] of `din` and of `dout`. The element k of column s uses `cfg` bit s*(P/2)+k. Let L = log2(P). A column s <= L-1 splits its vector into blocks of B = P>>s words. Element k in block b takes words b*B+2j and b*B+2j+1 (j = k mod B/2) and drives words b*B+j and b*B+B/2+j. A column s >= L uses B = P>>(2L-2-s). Its element takes words b*B+j and b*B+B/2+j and drives b*B+2j and b*B+2j+1.
- R3: For any configuration, `dout` contains each input word exactly once.
- R4: Over all configuration vectors, every one of the P! orderings of the inputs appears at `dout`.
- R5: An element whose bit is set in `CONST_MASK` stays in the state given by the same bit of `CONST_STATE` (0 pass, 1 cross).
- R6: The `cfg` bit of an element marked in `CONST_MASK` has no effect on `dout`.
- R7: A build with a constant mask gives the same `dout` as a fully switched build whose masked bits carry the constant states and whose other bits match.
- R8: With `PIPE`=1, each data vector appears at `dout` exactly `2*log2(P)-1` cycles after it is presented, permuted by the configuration presented in the same cycle. When inputs are held, the output settles and stays stable.
- R9: With `PIPE`=1, all column registers clear to zero while `rst_n` is low, so `dout` reads zero.
- R10: With `PIPE`=0, `dout` follows `din` and `cfg` in the same cycle, with no clock involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the column registers and configuration delay lines |
| rst_n | input | 1 | Active-low synchronous reset |
| din | input | P*W | Input words, word i at bits [i*W +: W] |
| cfg | input | (2*log2(P)-1)*(P/2) | One setting bit per element, column-major |
| dout | output | P*W | Permuted output words |

## Verification
A wrong element state or a miswired column shows at `dout` as a word in the wrong place. If distinct words are applied, it shows in the same cycle for the combinational build, or after exactly `2*log2(P)-1` cycles for the pipelined build. A delay line of the wrong length pairs a vector with a neighbour's settings. That shows as a mismatch as soon as the configuration changes between consecutive cycles. A hardwired element in the wrong state, or one that still obeys its bit, shows as a difference between the masked and fully switched builds. It can also show as an output that moves when only masked bits change.

// File: rtl/benes_pkg.sv
package benes_pkg;

   // Block size of column s in a network of p words.
   function automatic int col_block(input int p, input int s);
      int l;
      l = $clog2(p);
      if (s <= l - 1) return p >> s;
      return p >> (2 * l - 2 - s);
   endfunction

   // Word index feeding port `which` of element k in column s.
   function automatic int src_idx(input int p, input int s, input int k, input int which);
      int b, h, base, j;
      b    = col_block(p, s);
      h    = b / 2;
      base = (k / h) * b;
      j    = k % h;
      if (s <= $clog2(p) - 1) return base + 2 * j + which;
      return base + j + which * h;
   endfunction

   // Word index driven by port `which` of element k in column s.
   function automatic int dst_idx(input int p, input int s, input int k, input int which);
      int b, h, base, j;
      b    = col_block(p, s);
      h    = b / 2;
      base = (k / h) * b;
      j    = k % h;
      if (s <= $clog2(p) - 1) return base + j + which * h;
      return base + 2 * j + which;
   endfunction

endpackage

// File: rtl/benes_switch.sv
module benes_switch #(
   parameter int W           = 8,
   parameter bit FIXED       = 1'b0,
   parameter bit FIXED_CROSS = 1'b0
) (
   input  logic [W-1:0] a0,
   input  logic [W-1:0] a1,
   input  logic         sel,
   output logic [W-1:0] y0,
   output logic [W-1:0] y1
);

   generate
      if (FIXED) begin : g_wired
         logic unused_sel;
         assign unused_sel = sel;
         if (FIXED_CROSS) begin : g_cross
            assign y0 = a1;
            assign y1 = a0;
         end else begin : g_pass
            assign y0 = a0;
            assign y1 = a1;
         end
      end else begin : g_mux
         assign y0 = sel ? a1 : a0;
         assign y1 = sel ? a0 : a1;
      end
   endgenerate

endmodule

// File: rtl/benes_stage.sv
module benes_stage #(
   parameter int             P         = 8,
   parameter int             W         = 8,
   parameter int             STAGE     = 0,
   parameter int             LAG       = 0,
   parameter bit             PIPE      = 1'b0,
   parameter logic [P/2-1:0] FIX_MASK  = '0,
   parameter logic [P/2-1:0] FIX_STATE = '0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [P-1:0][W-1:0]   d_in,
   input  logic [P/2-1:0]        sel_in,
   output logic [P-1:0][W-1:0]   d_out
);

   localparam int H  = P / 2;
   localparam int SW = W + $clog2(P);

   logic [H-1:0]          sel_now;
   logic [P-1:0][W-1:0]   sw_out;

   // configuration delay so settings meet the data they came with
   generate
      if (LAG == 0) begin : g_no_lag
         assign sel_now = sel_in;
      end else begin : g_lag
         logic [LAG-1:0][H-1:0] sel_q;
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               sel_q <= '0;
            end else begin
               sel_q[0] <= sel_in;
               for (int i = 1; i < LAG; i++) sel_q[i] <= sel_q[i-1];
            end
         end
         assign sel_now = sel_q[LAG-1];
      end
   endgenerate

   generate
      for (genvar k = 0; k < H; k++) begin : g_sw
         localparam int IA = benes_pkg::src_idx(P, STAGE, k, 0);
         localparam int IB = benes_pkg::src_idx(P, STAGE, k, 1);
         localparam int OA = benes_pkg::dst_idx(P, STAGE, k, 0);
         localparam int OB = benes_pkg::dst_idx(P, STAGE, k, 1);

         benes_switch #(
            .W          (W),
            .FIXED      (FIX_MASK[k]),
            .FIXED_CROSS(FIX_STATE[k])
         ) u_sw (
            .a0 (d_in[IA]),
            .a1 (d_in[IB]),
            .sel(sel_now[k]),
            .y0 (sw_out[OA]),
            .y1 (sw_out[OB])
         );

         // R3: two different words entering an element leave as two different words
         p_distinct_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (d_in[IA] != d_in[IB]) |-> (sw_out[OA] != sw_out[OB]));
      end
   endgenerate

   generate
      if (PIPE) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n) d_out <= '0;
            else        d_out <= sw_out;
         end
      end else begin : g_comb
         assign d_out = sw_out;
      end
   endgenerate

   // conservation of the word multiset across the column
   logic [W-1:0]  xor_in, xor_sw;
   logic [SW-1:0] sum_in, sum_sw;
   always_comb begin
      xor_in = '0; xor_sw = '0; sum_in = '0; sum_sw = '0;
      for (int i = 0; i < P; i++) begin
         xor_in = xor_in ^ d_in[i];
         xor_sw = xor_sw ^ sw_out[i];
         sum_in = sum_in + SW'(d_in[i]);
         sum_sw = sum_sw + SW'(sw_out[i]);
      end
   end

   p_xor_kept_r3: assert property (@(posedge clk) disable iff (!rst_n) xor_sw == xor_in);
   p_sum_kept_r3: assert property (@(posedge clk) disable iff (!rst_n) sum_sw == sum_in);

endmodule

// File: rtl/benes_perm_net.sv
module benes_perm_net #(
   parameter int P    = 8,
   parameter int W    = 8,
   parameter bit PIPE = 1'b0,
   parameter logic [(2*$clog2(P)-1)*(P/2)-1:0] CONST_MASK  = '0,
   parameter logic [(2*$clog2(P)-1)*(P/2)-1:0] CONST_STATE = '0
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [P*W-1:0]                  din,
   input  logic [(2*$clog2(P)-1)*(P/2)-1:0] cfg,
   output logic [P*W-1:0]                  dout
);

   localparam int L   = $clog2(P);
   localparam int S   = 2 * L - 1;
   localparam int H   = P / 2;
   localparam int NSW = S * H;
   localparam int LAT = PIPE ? S : 0;
   localparam int CW  = $clog2(LAT + 3) + 1;

   generate
      if (P < 2 || (P & (P - 1)) != 0) begin : g_bad_p
         $error("benes_perm_net: P must be a power of two, at least 2");
      end
      if (W < 1) begin : g_bad_w
         $error("benes_perm_net: W must be at least 1");
      end
   endgenerate

   logic [P-1:0][W-1:0] lane [S+1];
   assign lane[0] = din;

   generate
      for (genvar s = 0; s < S; s++) begin : g_col
         benes_stage #(
            .P        (P),
            .W        (W),
            .STAGE    (s),
            .LAG      (PIPE ? s : 0),
            .PIPE     (PIPE),
            .FIX_MASK (CONST_MASK[s*H +: H]),
            .FIX_STATE(CONST_STATE[s*H +: H])
         ) u_col (
            .clk   (clk),
            .rst_n (rst_n),
            .d_in  (lane[s]),
            .sel_in(cfg[s*H +: H]),
            .d_out (lane[s+1])
         );
      end
   endgenerate

   assign dout = lane[S];

   // settle watch: inputs held for the full latency keep the output still
   logic [P*W-1:0] din_q;
   logic [NSW-1:0] cfg_q;
   logic [CW-1:0]  held_cnt;
   logic           same_now;
   assign same_now = (din == din_q) && (cfg == cfg_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         din_q    <= '0;
         cfg_q    <= '0;
         held_cnt <= '0;
      end else begin
         din_q <= din;
         cfg_q <= cfg;
         if (!same_now)                     held_cnt <= '0;
         else if (held_cnt < CW'(LAT + 2))  held_cnt <= held_cnt + 1'b1;
      end
   end

   p_settle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (same_now && held_cnt >= CW'(LAT + 1)) |-> $stable(dout));

endmodule

// File: tb/test_benes_perm_net.sv
module test_benes_perm_net;

   localparam logic [19:0] FMASK  = 20'hC0305;
   localparam logic [19:0] FSTATE = 20'h80301;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] din = '0, din_f = '0, din_p = '0;
   logic [19:0] cfg = '0, cfg_f = '0, cfg_p = '0;
   logic [63:0] dout, dout_f, dout_p;
   logic [31:0] din4 = '0;
   logic [5:0]  cfg4 = '0;
   logic [31:0] dout4;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   benes_perm_net #(.P(8), .W(8)) i_benes_perm_net (
      .clk(clk), .rst_n(rst_n), .din(din), .cfg(cfg), .dout(dout));

   benes_perm_net #(.P(8), .W(8), .CONST_MASK(FMASK), .CONST_STATE(FSTATE)) i_benes_perm_net_fixed (
      .clk(clk), .rst_n(rst_n), .din(din_f), .cfg(cfg_f), .dout(dout_f));

   benes_perm_net #(.P(8), .W(8), .PIPE(1'b1)) i_benes_perm_net_pipe (
      .clk(clk), .rst_n(rst_n), .din(din_p), .cfg(cfg_p), .dout(dout_p));

   benes_perm_net #(.P(4), .W(8)) i_benes_perm_net_p4 (
      .clk(clk), .rst_n(rst_n), .din(din4), .cfg(cfg4), .dout(dout4));

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // column-by-column model of the R2 wiring for P=8, W=8
   function automatic logic [63:0] model8(input logic [63:0] v, input logic [19:0] c);
      logic [7:0] cur [8];
      logic [7:0] nxt [8];
      logic [63:0] r;
      for (int i = 0; i < 8; i++) cur[i] = v[i*8 +: 8];
      for (int s = 0; s < 5; s++) begin
         int b, h;
         b = (s <= 2) ? (8 >> s) : (8 >> (4 - s));
         h = b / 2;
         for (int k = 0; k < 4; k++) begin
            int base, j, ia, ib, oa, ob;
            logic [7:0] x, y;
            base = (k / h) * b;
            j    = k % h;
            if (s <= 2) begin
               ia = base + 2*j; ib = ia + 1; oa = base + j; ob = oa + h;
            end else begin
               ia = base + j; ib = ia + h; oa = base + 2*j; ob = oa + 1;
            end
            x = cur[ia]; y = cur[ib];
            if (c[s*4 + k]) begin nxt[oa] = y; nxt[ob] = x; end
            else            begin nxt[oa] = x; nxt[ob] = y; end
         end
         for (int i = 0; i < 8; i++) cur[i] = nxt[i];
      end
      for (int i = 0; i < 8; i++) r[i*8 +: 8] = cur[i];
      return r;
   endfunction

   localparam logic [19:0] TCFG [8] = '{20'h00000, 20'hFFFFF, 20'h0F0F0, 20'hA5A5A,
                                        20'h12345, 20'hFEDCB, 20'h00100, 20'h80001};
   localparam logic [63:0] TDIN [8] = '{64'h0706050403020100, 64'h1122334455667788,
                                        64'hF0E1D2C3B4A59687, 64'h0102040810204080,
                                        64'hFF7F3F1F0F070301, 64'h8899AABBCCDDEEFF,
                                        64'h5A4B3C2D1E0F6978, 64'h7766554433221100};

   bit seen [256];
   logic [63:0] pexp [40];

   initial begin : main
      logic [63:0] ref_v, hold;
      logic [19:0] r;

      din_p = 64'hDEADBEEFCAFEF00D;
      cfg_p = 20'h5A5A5;
      repeat (3) @(negedge clk);
      #1;
      // R9: pipelined column registers read zero during reset
      chk(dout_p == 64'd0, "R9 reset clears pipeline", dout_p, 64'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // table of vectors on the combinational full build
      for (int t = 0; t < 8; t++) begin
         din = TDIN[t];
         cfg = TCFG[t];
         #1;
         ref_v = model8(TDIN[t], TCFG[t]);
         chk(dout == ref_v, "R2/R10 table vector", dout, ref_v);
         @(negedge clk);
      end

      // R1: all pass is identity
      din = 64'h0706050403020100; cfg = '0; #1;
      chk(dout == din, "R1 all-pass identity", dout, din);

      // R1/R2 on P=4: first element of column 0 crossed swaps words 0 and 1
      din4 = 32'h03020100; cfg4 = 6'b000001; #1;
      chk(dout4 == 32'h03020001, "R1 first column cross", {32'd0, dout4}, 64'h03020001);
      // middle column element 0 crossed swaps words 0 and 2
      cfg4 = 6'b000100; #1;
      chk(dout4 == 32'h03000102, "R2 middle column cross", {32'd0, dout4}, 64'h03000102);

      // R3/R4: exhaustive sweep of the P=4 network
      for (int c = 0; c < 64; c++) begin
         logic [3:0] mark;
         logic [7:0] code;
         cfg4 = 6'(c); #1;
         mark = '0; code = '0;
         for (int i = 0; i < 4; i++) begin
            mark[dout4[i*8 +: 2]] = 1'b1;
            code = code | (8'(dout4[i*8 +: 2]) << (2*i));
         end
         if (mark != 4'hF || dout4[31:26] != 0 || dout4[23:18] != 0 || dout4[15:10] != 0 || dout4[7:2] != 0)
            chk(1'b0, "R3 output not a rearrangement", {32'd0, dout4}, 64'h0);
         seen[code] = 1'b1;
      end
      begin
         int n;
         n = 0;
         for (int i = 0; i < 256; i++) if (seen[i]) n++;
         chk(n == 24, "R4 all orderings reached", 64'(n), 64'd24);
      end
      chk(1'b1, "R3 sweep completed", 64'd0, 64'd0);

      // R5/R7: masked build versus full build with constants folded in
      for (int t = 0; t < 12; t++) begin
         r     = 20'($urandom);
         din_f = {$urandom, $urandom};
         cfg_f = r;
         din   = din_f;
         cfg   = (r & ~FMASK) | (FSTATE & FMASK);
         #1;
         chk(dout_f == dout, "R7 masked equals full build", dout_f, dout);
         ref_v = model8(din_f, (r & ~FMASK) | (FSTATE & FMASK));
         chk(dout_f == ref_v, "R5 constant element states", dout_f, ref_v);
         @(negedge clk);
      end

      // R6: masked configuration bits have no effect
      din_f = 64'h0706050403020100;
      cfg_f = 20'h2468A; #1;
      hold = dout_f;
      cfg_f = 20'h2468A ^ FMASK; #1;
      chk(dout_f == hold, "R6 masked bits ignored", dout_f, hold);
      cfg_f = 20'h2468A | FMASK; #1;
      chk(dout_f == hold, "R6 masked bits ignored (all set)", dout_f, hold);

      // R8: pipelined stream, new data and settings every cycle
      for (int k = 0; k < 40; k++) pexp[k] = '0;
      for (int k = 0; k < 45; k++) begin
         @(negedge clk);
         if (k >= 5) chk(dout_p == pexp[k-5], "R8 pipeline latency and pairing", dout_p, pexp[k-5]);
         if (k < 40) begin
            din_p   = {$urandom, $urandom};
            cfg_p   = 20'($urandom);
            pexp[k] = model8(din_p, cfg_p);
         end
      end
      // R8: held inputs settle
      repeat (8) @(negedge clk);
      hold = dout_p;
      chk(dout_p == model8(din_p, cfg_p), "R8 settled output", dout_p, model8(din_p, cfg_p));
      @(negedge clk);
      chk(dout_p == hold, "R8 output stays still", dout_p, hold);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule